// File: doc/BRIEF.md
# Zero-Skip Sequential Shift-Add Multiplier

This block multiplies two unsigned W-bit operands (W = 4 by default) and delivers a 2W-bit product exactly W clock cycles after a start request is accepted. Each cycle it examines one multiplier bit, chosen by a one-hot ring counter that walks from the least significant position to the most significant.

When the chosen bit is one, a ripple-carry adder adds the multiplicand to the running upper partial product. The adder keeps its carry. When the chosen bit is zero, the adder result is not used. Instead, the upper partial product, padded with a zero in the carry position, is fed straight back. In both cases the selected value is shifted right by one to form the new upper half. Its lowest bit is written once into a dedicated lower-half cell, picked by the ring counter, and that cell never moves or changes again during the operation.

A host pulses start with operands on the inputs, then waits for the one-cycle done pulse. The product port is live throughout the operation and holds the final result until the next start.

Top module: `skipadd_mul`

## Requirements
- R1: A synchronous reset drives the product to zero and done low, and aborts any multiplication in progress so that no done pulse follows it.
- R2: A start that is accepted while idle is followed, exactly W rising edges later, by done high with the product equal to A*B, treated as unsigned values.
- R3: Done is high for exactly one cycle per multiplication.
- R4: Start, A and B are ignored while a multiplication is in progress; the result is that of the operands captured at the accepted start.
- R5: After k cycles of an operation (1 <= k <= W), let P_k = A*(B mod 2^k). The upper W bits of the product equal P_k >> k. Bits [k-1:0] equal P_k mod 2^k. Bits [W-1:k] are zero.
- R6: An accepted start clears the whole product to zero on the same edge that loads the operands.
- R7: The adder keeps its carry-out, so the largest operands (all ones) give (2^W-1)^2, for example 0xE1 for W = 4.
- R8: While idle and with no start, the product holds its value.
- R9: While busy, exactly one ring-counter bit is set. While idle, none is set. A lower-half cell changes only in the cycle its ring bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted only while idle |
| a_i | input | W | Multiplicand |
| b_i | input | W | Multiplier |
| prod_o | output | 2W | Upper partial product concatenated with the lower-half cells |
| done_o | output | 1 | One-cycle pulse when the product is final |

## Verification
The bound checker watches every cycle for the following:
- the ring counter is one-hot while busy and clear while idle;
- lower-half cells are written only under their own ring bit;
- captured operands stay frozen during an operation;
- the product holds while idle;
- done is a single-cycle pulse arriving exactly W cycles after acceptance.

Only the bench scenarios can show that the arithmetic is right. They compare the product after every cycle against the partial value computed from the operands, including the carry at all-ones and zero operands on either side. The scenarios also cover a start presented mid-operation and a reset that aborts a running multiplication.

// File: rtl/skipadd_pkg.sv
package skipadd_pkg;
    // Default operand width.
    parameter int unsigned DEFAULT_W = 4;

    // Which path feeds the upper partial product in a step.
    typedef enum logic {
        PATH_BYPASS = 1'b0,
        PATH_SUM    = 1'b1
    } path_e;
endpackage

// File: rtl/sa_ripple_add.sv
module sa_ripple_add #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W:0]   sum_o
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_o[i]    = x_i[i] ^ y_i[i] ^ carry[i];
        assign carry[i+1]  = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
    end

    assign sum_o[W] = carry[W];
endmodule

// File: rtl/sa_bit_pick.sv
module sa_bit_pick #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] sel_i,
    input  logic [W-1:0] bits_i,
    output logic         bit_o
);
    // AND-OR select by a one-hot vector; zero when nothing is selected.
    assign bit_o = |(sel_i & bits_i);
endmodule

// File: rtl/sa_low_store.sv
module sa_low_store #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic [W-1:0] en_i,
    input  logic         din_i,
    output logic [W-1:0] q_o
);
    // One enabled cell per lower product bit; cells never shift.
    for (genvar i = 0; i < W; i++) begin : g_cell
        always_ff @(posedge clk_i) begin
            if (rst_i || clr_i) begin
                q_o[i] <= 1'b0;
            end else if (en_i[i]) begin
                q_o[i] <= din_i;
            end
        end
    end
endmodule

// File: rtl/skipadd_mul.sv
module skipadd_mul
    import skipadd_pkg::*;
#(
    parameter int unsigned W = DEFAULT_W
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           start_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o,
    output logic           done_o
);
    localparam int unsigned SW = W + 1;

    typedef struct packed {
        logic         busy;
        logic         done;
        logic [W-1:0] ring;
        logic [W-1:0] feeder;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } state_t;

    state_t st_d, st_q;

    logic [SW-1:0] sum_w;
    logic [SW-1:0] bypass_w;
    logic [SW-1:0] chosen_w;
    logic          mbit_w;
    path_e         path_w;
    logic          clr_w;
    logic [W-1:0]  en_w;
    logic [W-1:0]  low_q;

    sa_ripple_add #(.W(W)) u_add (
        .x_i   (st_q.feeder),
        .y_i   (st_q.a),
        .sum_o (sum_w)
    );

    sa_bit_pick #(.W(W)) u_pick (
        .sel_i  (st_q.ring),
        .bits_i (st_q.b),
        .bit_o  (mbit_w)
    );

    sa_low_store #(.W(W)) u_low (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (clr_w),
        .en_i  (en_w),
        .din_i (chosen_w[0]),
        .q_o   (low_q)
    );

    // Bypass value: feeder with a zero carry position, same shift as the sum path.
    assign bypass_w = {1'b0, st_q.feeder};
    assign path_w   = mbit_w ? PATH_SUM : PATH_BYPASS;
    assign chosen_w = (path_w == PATH_SUM) ? sum_w : bypass_w;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_w     = 1'b0;
        en_w      = '0;
        if (st_q.busy) begin
            st_d.feeder = chosen_w[SW-1:1];
            en_w        = st_q.ring;
            st_d.ring   = st_q.ring << 1;
            if (st_q.ring[W-1]) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i) begin
            st_d.busy   = 1'b1;
            st_d.a      = a_i;
            st_d.b      = b_i;
            st_d.feeder = '0;
            st_d.ring   = {{(W-1){1'b0}}, 1'b1};
            clr_w       = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_o = {st_q.feeder, low_q};
    assign done_o = st_q.done;
endmodule

// File: rtl/skipadd_mul_chk.sv
module skipadd_mul_chk #(
    parameter int unsigned W = 4
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           start_i,
    input logic           busy_i,
    input logic           done_i,
    input logic [W-1:0]   ring_i,
    input logic [W-1:0]   low_i,
    input logic [2*W-1:0] prod_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i
);
    localparam int unsigned CW = $clog2(W + 1) + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (!busy_i && start_i) begin
            cnt_q <= '0;
        end else if (busy_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: done is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |=> !done_i);

    // R2: done arrives exactly W busy cycles after acceptance
    a_r2_done_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |-> (cnt_q == CW'(W)));

    // R9: ring counter one-hot while busy, clear while idle
    a_r9_ring_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |-> $onehot(ring_i));

    a_r9_ring_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_i |-> (ring_i == '0));

    // R4: captured operands frozen during an operation
    a_r4_ops_held: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |=> ($stable(a_i) && $stable(b_i)));

    // R8: product held while idle without start
    a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_i && !start_i) |=> $stable(prod_i));

    // R9: a lower cell changes only under its own ring bit
    for (genvar i = 0; i < W; i++) begin : g_low
        a_r9_low_in_place: assert property (@(posedge clk_i) disable iff (rst_i)
            (busy_i && !ring_i[i]) |=> $stable(low_i[i]));
    end
endmodule

bind skipadd_mul skipadd_mul_chk #(.W(W)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .busy_i  (st_q.busy),
    .done_i  (done_o),
    .ring_i  (st_q.ring),
    .low_i   (low_q),
    .prod_i  (prod_o),
    .a_i     (st_q.a),
    .b_i     (st_q.b)
);

// File: tb/skipadd_mul_tb_top.sv
module skipadd_mul_tb_top;
    localparam int W  = 4;
    localparam int PW = 2 * W;
    localparam int NV = 8;

    // {a, b, expected product}
    localparam logic [15:0] VEC [NV] = '{
        {4'd3,  4'd3,  8'h09},
        {4'd15, 4'd15, 8'hE1},
        {4'd0,  4'd9,  8'h00},
        {4'd9,  4'd0,  8'h00},
        {4'd10, 4'd5,  8'h32},
        {4'd1,  4'd15, 8'h0F},
        {4'd8,  4'd8,  8'h40},
        {4'd7,  4'd12, 8'h54}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic [PW-1:0] prod;
    logic          done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    skipadd_mul #(.W(W)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .a_i     (a_in),
        .b_i     (b_in),
        .prod_o  (prod),
        .done_o  (done)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_mid(int a, int b, int k);
        int bk = b & ((1 << k) - 1);
        int p  = a * bk;
        return ((p >> k) << W) | (p & ((1 << k) - 1));
    endfunction

    task automatic run_op(int a, int b, int exp_final);
        @(negedge clk);
        start = 1'b1; a_in = W'(a); b_in = W'(b);
        @(negedge clk);
        start = 1'b0; a_in = '0; b_in = '0;
        chk("R6 cleared on start", int'(prod), 0);
        chk("R3 done low after start", int'(done), 0);
        for (int k = 1; k <= W; k++) begin
            @(negedge clk);
            chk("R5 partial product", int'(prod), exp_mid(a, b, k));
            chk("R2 done timing", int'(done), (k == W) ? 1 : 0);
        end
        chk("R2 final product", int'(prod), exp_final);
        @(negedge clk);
        chk("R3 done single cycle", int'(done), 0);
        chk("R8 product held", int'(prod), exp_final);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 reset product", int'(prod), 0);
        chk("R1 reset done", int'(done), 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_op(int'(VEC[v][15:12]), int'(VEC[v][11:8]), int'(VEC[v][7:0]));
        end

        // R7: carry kept at all-ones operands
        run_op(15, 15, 225);
        chk("R7 carry kept", int'(prod), 8'hE1);

        // R4: start with new operands during busy is ignored
        @(negedge clk);
        start = 1'b1; a_in = 4'd5; b_in = 4'd6;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; a_in = 4'd15; b_in = 4'd15;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R4 done after original start", int'(done), 1);
        chk("R4 operands kept", int'(prod), 30);
        @(negedge clk);
        chk("R4 no second done", int'(done), 0);
        chk("R4 product unchanged", int'(prod), 30);

        // R8: idle hold over several cycles
        repeat (3) @(negedge clk);
        chk("R8 idle hold", int'(prod), 30);

        // R1: reset aborts a running operation
        @(negedge clk);
        start = 1'b1; a_in = 4'd7; b_in = 4'd9;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears product", int'(prod), 0);
        chk("R1 reset clears done", int'(done), 0);
        for (int k = 0; k < W + 2; k++) begin
            @(negedge clk);
            chk("R1 no done after abort", int'(done), 0);
        end

        // Operation after abort still correct
        run_op(6, 11, 66);

        summary();
        $finish;
    end
endmodule